// File: doc/BRIEF.md
# Transparent Region Matcher

This block sits in front of a paged address translator and decides, for every access, whether the logical address lies inside a transparent region. An address in such a region is passed through untranslated, and no table walk starts for it. The block holds four region registers. Two serve instruction fetches and two serve data accesses, and all four are loaded through a small write port. Each access presents an address, a 3-bit function code, a write flag and a probe flag. The block answers in the same cycle with a hit, the pass-through physical address, a write-protect fault and an illegal-class flag.

Matching runs whether or not paged translation is enabled, so there is no enable input from the translator. Within a class pair, region 0 takes priority over region 1. A region marked write-protected raises a fault on a write access. A probe access never raises that fault, but it still reports the hit.

Top module: `tt_region_matcher`

## Requirements
- R1: After reset all four regions are disabled: no access hits, `paddr_o` is 0 and `wp_fault_o` is 0.
- R2: A region register takes part in matching only when its bit 15 (enable) is 1. A disabled region never hits and never faults, whatever its other fields hold.
- R3: A region matches when `addr_i[31:24]` equals register bits 31:24 (base) in every bit position where register bits 23:16 (ignore mask) hold 0. Positions whose mask bit is 1 are not compared.
- R4: `fc_i[0]`=1 selects the data pair (register slots 2 and 3). `fc_i[0]`=0 with `fc_i[1]`=1 selects the instruction pair (slots 0 and 1). `fc_i[2]` has no effect on the result.
- R5: When both regions of the selected pair match, only region 0 (the lower slot of the pair) decides the write-protect outcome.
- R6: On a hit, `paddr_o` equals `addr_i`. On a miss, `paddr_o` is 0.
- R7: `wp_fault_o` is 1 exactly when the access hits, the deciding region has register bit 2 (write-protect) set, `wr_i`=1 and `probe_i`=0. Read accesses never fault.
- R8: With `probe_i`=1, `wp_fault_o` stays 0 while `hit_o` and `paddr_o` behave as for a normal access.
- R9: A function code with `fc_i[1:0]`=00 gives `hit_o`=0, `wp_fault_o`=0 and `illegal_o`=1. Any other code gives `illegal_o`=0.
- R10: The outputs are combinational in the access inputs. A write with `cfg_we_i`=1 loads slot `cfg_sel_i` (bit 1 = class, 1 for data; bit 0 = region) at the next rising clock edge. Before that edge the old contents still apply, and the other slots are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Region register write strobe |
| cfg_sel_i | input | 2 | Slot select: bit 1 class (1 = data), bit 0 region index |
| cfg_wdata_i | input | 32 | Region register write value |
| addr_i | input | 32 | Logical address of the access |
| fc_i | input | 3 | Function code of the access |
| wr_i | input | 1 | Access is a write |
| probe_i | input | 1 | Access is a probe that reports but does not fault |
| hit_o | output | 1 | Address lies in an enabled region of the selected pair |
| paddr_o | output | 32 | Pass-through physical address on hit, 0 otherwise |
| wp_fault_o | output | 1 | Write-protect fault |
| illegal_o | output | 1 | Function code selects neither class |

## Verification
A register write and an access can fall in the same cycle. The bench drives a write strobe for a slot while an access that the write would change is held on the inputs. Just before the clock edge it expects the outcome given by the old register contents, and just after the edge it expects the outcome given by the new contents. The same test confirms that the other class's slots still give their earlier results.

// File: rtl/tt_match_pkg.sv
package tt_match_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned TAG_W    = 8;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned WP_BIT   = 2;
  localparam int unsigned BASE_LSB = 24;
  localparam int unsigned MASK_LSB = 16;
  localparam int unsigned NUM_CLASSES = 2;

  localparam logic [REG_W-1:0] USED_MASK =
      ({{(REG_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << BASE_LSB) |
      ({{(REG_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << MASK_LSB) |
      (REG_W'(1) << EN_BIT) | (REG_W'(1) << WP_BIT);

  typedef struct packed {
    logic             en;
    logic             wp;
    logic [TAG_W-1:0] base;
    logic [TAG_W-1:0] ign;
  } region_t;

  function automatic region_t decode_region(input logic [REG_W-1:0] w);
    region_t r;
    r.en   = w[EN_BIT];
    r.wp   = w[WP_BIT];
    r.base = w[BASE_LSB +: TAG_W];
    r.ign  = w[MASK_LSB +: TAG_W];
    return r;
  endfunction
endpackage

// File: rtl/tt_reg_bank.sv
module tt_reg_bank
  import tt_match_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_SLOTS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [REG_W-1:0]        wdata_i,
  output region_t [NUM_SLOTS-1:0] slot_o
);
  region_t [NUM_SLOTS-1:0] slot_q;
  region_t                 wr_rgn;
  logic                    unused_wdata;

  // only decoded fields are stored
  assign wr_rgn       = decode_region(wdata_i);
  assign unused_wdata = ^(wdata_i & ~USED_MASK);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[s] <= '0;
      else if (we_i && sel_i == SEL_W'(s))  slot_q[s] <= wr_rgn;
    end
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/tt_region_cmp.sv
module tt_region_cmp
  import tt_match_pkg::*;
(
  input  region_t          rgn_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             match_o,
  output logic             wp_o
);
  assign match_o = rgn_i.en && (((tag_i ^ rgn_i.base) & ~rgn_i.ign) == '0);
  assign wp_o    = rgn_i.wp;
endmodule

// File: rtl/tt_prio_pick.sv
module tt_prio_pick #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] match_i,
  input  logic [N-1:0] wp_i,
  output logic         hit_o,
  output logic         wp_o
);
  // lowest index wins
  always_comb begin
    hit_o = |match_i;
    wp_o  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) wp_o = wp_i[i];
    end
  end
endmodule

// File: rtl/tt_region_matcher.sv
module tt_region_matcher
  import tt_match_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_REGIONS = 2,  // power of two
  localparam int unsigned NUM_SLOTS  = NUM_CLASSES * NUM_REGIONS,
  localparam int unsigned SEL_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              wr_i,
  input  logic              probe_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              wp_fault_o,
  output logic              illegal_o
);
  region_t [NUM_SLOTS-1:0]   bank;
  region_t [NUM_REGIONS-1:0] act_rgn;
  logic [NUM_REGIONS-1:0]    rgn_match;
  logic [NUM_REGIONS-1:0]    rgn_wp;
  logic                      is_data, legal, any_hit, pick_wp;
  logic                      unused_fc;

  tt_reg_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .slot_o  (bank)
  );

  // class: data wins when bit 0 set; supervisor bit not used
  assign is_data   = fc_i[0];
  assign legal     = fc_i[0] | fc_i[1];
  assign unused_fc = fc_i[2];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    assign act_rgn[r] = is_data ? bank[NUM_REGIONS + r] : bank[r];
    tt_region_cmp u_cmp (
      .rgn_i   (act_rgn[r]),
      .tag_i   (addr_i[ADDR_W-1 -: TAG_W]),
      .match_o (rgn_match[r]),
      .wp_o    (rgn_wp[r])
    );
  end

  tt_prio_pick #(.N(NUM_REGIONS)) u_pick (
    .match_i (rgn_match),
    .wp_i    (rgn_wp),
    .hit_o   (any_hit),
    .wp_o    (pick_wp)
  );

  assign hit_o      = legal & any_hit;
  assign paddr_o    = hit_o ? addr_i : '0;
  assign wp_fault_o = hit_o & pick_wp & wr_i & ~probe_i;
  assign illegal_o  = ~legal;
endmodule

// File: rtl/tt_region_matcher_chk.sv
module tt_region_matcher_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        fc_lo_i,
  input logic              wr_i,
  input logic              probe_i,
  input logic              hit_o,
  input logic [ADDR_W-1:0] paddr_o,
  input logic              wp_fault_o,
  input logic              illegal_o
);
  a_r6_paddr_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o == addr_i);
  a_r6_paddr_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> paddr_o == '0);
  a_r7_fault_needs_write_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_fault_o |-> (hit_o && wr_i));
  a_r8_probe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_i |-> !wp_fault_o);
  a_r9_bad_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_lo_i == 2'b00) |-> (illegal_o && !hit_o && !wp_fault_o));
  a_r9_good_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_lo_i != 2'b00) |-> !illegal_o);
endmodule

bind tt_region_matcher tt_region_matcher_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .fc_lo_i    (fc_i[1:0]),
  .wr_i       (wr_i),
  .probe_i    (probe_i),
  .hit_o      (hit_o),
  .paddr_o    (paddr_o),
  .wp_fault_o (wp_fault_o),
  .illegal_o  (illegal_o)
);

// File: tb/tt_region_matcher_tb.sv
module tt_region_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        wr = 1'b0;
  logic        probe = 1'b0;
  logic        hit, wp_fault, illegal;
  logic [31:0] paddr;

  int total = 0;
  int fails = 0;
  logic [31:0] sh [4];

  always #10 clk = ~clk;

  tt_region_matcher u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .addr_i(addr), .fc_i(fc), .wr_i(wr),
    .probe_i(probe), .hit_o(hit), .paddr_o(paddr), .wp_fault_o(wp_fault),
    .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ref_model(input logic [31:0] a, input logic [2:0] f, input logic w, input logic p,
                           output logic e_hit, output logic e_wp, output logic e_ill);
    int b;
    e_hit = 1'b0; e_wp = 1'b0; e_ill = (f[1:0] == 2'b00);
    b = f[0] ? 2 : 0;
    if (!e_ill) begin
      for (int r = 0; r < 2; r++) begin
        if (!e_hit && sh[b+r][15] &&
            (((a[31:24] ^ sh[b+r][31:24]) & ~sh[b+r][23:16]) == 8'h00)) begin
          e_hit = 1'b1;
          e_wp  = sh[b+r][2] & w & ~p;
        end
      end
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    sh[s] = d;
  endtask

  task automatic apply(input logic [31:0] a, input logic [2:0] f, input logic w, input logic p);
    addr = a; fc = f; wr = w; probe = p;
    #1;
  endtask

  task automatic sweep();
    logic eh, ew, ei;
    for (int t = 0; t < 256; t++) begin
      for (int f = 0; f < 8; f++) begin
        for (int m = 0; m < 4; m++) begin
          logic [31:0] a;
          a = {t[7:0], 24'(t * 40503 + f * 977 + m)};
          apply(a, f[2:0], m[0], m[1]);
          ref_model(a, f[2:0], m[0], m[1], eh, ew, ei);
          chk(hit == eh, "R3 hit", {31'b0, hit}, {31'b0, eh});
          chk(paddr == (eh ? a : 32'h0), "R6 paddr", paddr, eh ? a : 32'h0);
          chk(wp_fault == ew, "R7 wp_fault", {31'b0, wp_fault}, {31'b0, ew});
          chk(illegal == ei, "R9 illegal", {31'b0, illegal}, {31'b0, ei});
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    apply(32'h4000_0000, 3'd2, 1'b1, 1'b0);
    chk(!hit && paddr == 0 && !wp_fault, "R1 reset no hit", {31'b0, hit}, 32'h0);
    sweep();

    // config A
    wr_reg(2'd0, 32'h400F_8004);
    wr_reg(2'd1, 32'h403F_8000);
    wr_reg(2'd2, 32'h8000_8000);
    wr_reg(2'd3, 32'h807F_8004);
    sweep();

    // R5 priority: both data regions match, region 0 has no write-protect
    apply(32'h8000_1234, 3'd1, 1'b1, 1'b0);
    chk(hit && !wp_fault, "R5 region0 wins", {30'b0, hit, wp_fault}, 32'h2);
    apply(32'h8100_0000, 3'd1, 1'b1, 1'b0);
    chk(hit && wp_fault, "R5 region1 alone", {30'b0, hit, wp_fault}, 32'h3);
    // R4 class select
    apply(32'h4000_0000, 3'd2, 1'b1, 1'b0);
    chk(hit && wp_fault, "R4 program uses instr pair", {30'b0, hit, wp_fault}, 32'h3);
    apply(32'h4000_0000, 3'd6, 1'b1, 1'b0);
    chk(hit && wp_fault, "R4 fc bit2 no effect", {30'b0, hit, wp_fault}, 32'h3);
    apply(32'h4000_0000, 3'd1, 1'b1, 1'b0);
    chk(!hit, "R4 data misses instr region", {31'b0, hit}, 32'h0);
    apply(32'h4000_0000, 3'd3, 1'b1, 1'b0);
    chk(!hit, "R4 fc 3 is data", {31'b0, hit}, 32'h0);
    // R8 probe
    apply(32'h8100_0000, 3'd1, 1'b1, 1'b1);
    chk(hit && !wp_fault && paddr == 32'h8100_0000, "R8 probe hit no fault", {30'b0, hit, wp_fault}, 32'h2);
    // R7 read never faults
    apply(32'h8100_0000, 3'd1, 1'b0, 1'b0);
    chk(hit && !wp_fault, "R7 read no fault", {30'b0, hit, wp_fault}, 32'h2);

    // config B: instr region 0 disabled with tag and write-protect set
    wr_reg(2'd0, 32'h1200_0004);
    wr_reg(2'd1, 32'h00FF_8000);
    sweep();
    apply(32'h1200_0000, 3'd2, 1'b1, 1'b0);
    chk(hit && !wp_fault, "R2 disabled region ignored", {30'b0, hit, wp_fault}, 32'h2);

    // R10 write and access in the same cycle
    apply(32'h1200_0000, 3'd2, 1'b1, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h1200_8004;
    #1;
    chk(!wp_fault, "R10 old value before edge", {31'b0, wp_fault}, 32'h0);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    sh[0] = 32'h1200_8004;
    chk(hit && wp_fault, "R10 new value after edge", {30'b0, hit, wp_fault}, 32'h3);
    apply(32'h8000_0000, 3'd1, 1'b0, 1'b0);
    chk(hit, "R10 other slots untouched", {31'b0, hit}, 32'h1);
    sweep();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule